// File: doc/BRIEF.md
# Hybrid Rule-90/150 Cellular Automaton Pattern Source

This block produces pseudo-random parallel test stimulus for logic self-test. It is a one-dimensional row of cells. On each enabled clock every cell computes its next value from its two direct neighbours. A cell set to rule 150 also includes its own current value. The two ends of the row see a constant zero in place of the missing neighbour. A rule mask fixed at elaboration assigns rule 90 or rule 150 to each cell, and that mask, together with the row length, fixes the order in which patterns appear.

A test controller starts the generator in one of two ways: it loads a seed, or it lets reset place the default seed. It then pulses or holds the enable to advance one pattern per clock. The whole row is presented in parallel on the pattern output, with cell i on bit i. The reset input clears the state asynchronously. Its release is synchronized internally, so stepping and loading take effect only from the third rising clock edge after reset rises.

Top module: `ca_pattern_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after its synchronized release, the pattern equals the parameter RESET_SEED (default 1, meaning only cell 0 set). Asserting reset forces this value without waiting for a clock edge.
- R2: With step_en and seed_load both low, the pattern does not change across a clock edge.
- R3: When seed_load is high at a clock edge, the pattern on the next cycle equals seed_value. This applies whatever step_en is doing, so loading wins over stepping.
- R4: With step_en high and seed_load low, every cell takes the XOR of its lower and upper neighbours. A rule-150 cell also XORs in its own value. Bit i of the parameter RULES selects the rule of cell i: 0 selects rule 90, 1 selects rule 150.
- R5: Cell 0 has no lower neighbour and the last cell has no upper neighbour; in both places a constant 0 is used. With 4 cells and the default rules, the state 0x1 steps to 0x3.
- R6: With 4 cells, RULES = 4'b0101 (cells 0..3 use 150, 90, 150, 90), starting from 0x8, the pattern runs 8, 4, E, F, C, A, 1, 3, 6, B, 2, 5, D, 9, 7 in hex and then returns to 8.
- R7: With 7 cells and RULES = 7'b1101010, the pattern passes through 127 distinct nonzero values before it returns to the starting seed.
- R8: The all-zero state is a fixed point: once zero is loaded, stepping keeps the pattern at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| step_en | input | 1 | Advance the automaton by one generation |
| seed_load | input | 1 | Replace the state with seed_value; has priority over step_en |
| seed_value | input | CELLS | Seed to load, bit i goes to cell i |
| pattern | output | CELLS | Current cell states, bit i is cell i |

## Verification
Seed loading and stepping can be requested on the same edge. The bench provokes this by raising seed_load and step_en together while the row holds a known state. It then checks that the next pattern is exactly the seed, and not the successor of either the old state or the seed. The bound checker states the same priority at every load edge. A separate property confirms that the pattern stays put when neither request is made.

// File: rtl/ca_pkg.sv
package ca_pkg;

  typedef enum logic {
    RULE_90  = 1'b0,
    RULE_150 = 1'b1
  } ca_rule_e;

endpackage

// File: rtl/ca_rst_sync.sv
module ca_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/ca_cell.sv
module ca_cell #(
  parameter ca_pkg::ca_rule_e RULE = ca_pkg::RULE_90
) (
  input  logic lower_nb,
  input  logic self_val,
  input  logic upper_nb,
  output logic next_val
);

  localparam logic USE_SELF = (RULE == ca_pkg::RULE_150);

  always_comb begin
    next_val = lower_nb ^ upper_nb ^ (self_val & USE_SELF);
  end

endmodule

// File: rtl/ca_step.sv
module ca_step #(
  parameter int                CELLS = 4,
  parameter logic [CELLS-1:0]  RULES = '0
) (
  input  logic [CELLS-1:0] cur_state,
  output logic [CELLS-1:0] nxt_state
);

  localparam int PAD_W = CELLS + 2;

  // Null boundaries: a zero sits below cell 0 and above the last cell.
  logic [PAD_W-1:0] padded;
  assign padded = {1'b0, cur_state, 1'b0};

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    ca_cell #(
      .RULE(ca_pkg::ca_rule_e'(RULES[i]))
    ) u_cell (
      .lower_nb (padded[i]),
      .self_val (padded[i+1]),
      .upper_nb (padded[i+2]),
      .next_val (nxt_state[i])
    );
  end

endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen #(
  parameter int                   CELLS      = 4,
  parameter int                   RULE_BITS  = CELLS,
  parameter logic [RULE_BITS-1:0] RULES      = 4'b0101,
  parameter logic [CELLS-1:0]     RESET_SEED = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             seed_load,
  input  logic [CELLS-1:0] seed_value,
  output logic [CELLS-1:0] pattern
);

  if (RULE_BITS != CELLS) begin : g_rule_width_bad
    $error("ca_pattern_gen: rule mask width must equal CELLS");
  end

  localparam logic [CELLS-1:0] RULE_MASK = RULES[CELLS-1:0];

  logic             rst_n_s;
  logic [CELLS-1:0] state_q;
  logic [CELLS-1:0] state_d;
  logic [CELLS-1:0] step_out;

  ca_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ca_step #(
    .CELLS (CELLS),
    .RULES (RULE_MASK)
  ) u_step (
    .cur_state (state_q),
    .nxt_state (step_out)
  );

  always_comb begin
    if (seed_load) begin
      state_d = seed_value;
    end else if (step_en) begin
      state_d = step_out;
    end else begin
      state_d = state_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= RESET_SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign pattern = state_q;

endmodule

// File: rtl/ca_pattern_gen_chk.sv
module ca_pattern_gen_chk #(
  parameter int               CELLS      = 4,
  parameter logic             RULE_LO    = 1'b0,
  parameter logic             RULE_HI    = 1'b0,
  parameter logic [CELLS-1:0] RESET_SEED = 1
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             step_en,
  input logic             seed_load,
  input logic [CELLS-1:0] seed_value,
  input logic [CELLS-1:0] pattern
);

  // R1
  reset_seed_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> pattern == RESET_SEED);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!step_en && !seed_load) |=> $stable(pattern));

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    seed_load |=> pattern == $past(seed_value));

  // R8
  zero_lock_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!seed_load && pattern == '0) |=> pattern == '0);

  if (CELLS >= 2) begin : g_edges
    // R5
    low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (step_en && !seed_load) |=>
        pattern[0] == ($past(pattern[1]) ^ ($past(pattern[0]) & RULE_LO)));

    // R5
    high_edge_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
      (step_en && !seed_load) |=>
        pattern[CELLS-1] == ($past(pattern[CELLS-2]) ^ ($past(pattern[CELLS-1]) & RULE_HI)));
  end

endmodule

bind ca_pattern_gen ca_pattern_gen_chk #(
  .CELLS      (CELLS),
  .RULE_LO    (RULES[0]),
  .RULE_HI    (RULES[CELLS-1]),
  .RESET_SEED (RESET_SEED)
) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .step_en    (step_en),
  .seed_load  (seed_load),
  .seed_value (seed_value),
  .pattern    (pattern)
);

// File: tb/ca_pattern_gen_bench.sv
module ca_pattern_gen_bench;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } sb_item_t;

  logic       clk;
  logic       rst_n;
  logic       en4, ld4;
  logic [3:0] seed4, pat4;
  logic       en7, ld7;
  logic [6:0] seed7, pat7;

  int checks;
  int errors;
  sb_item_t sb_q[$];

  // Expected 4-cell orbit from 0x8, cell i on bit i.
  logic [3:0] orbit [15] = '{4'h8, 4'h4, 4'hE, 4'hF, 4'hC, 4'hA, 4'h1, 4'h3,
                             4'h6, 4'hB, 4'h2, 4'h5, 4'hD, 4'h9, 4'h7};

  ca_pattern_gen u_ca_pattern_gen (
    .clk(clk), .rst_n(rst_n), .step_en(en4), .seed_load(ld4),
    .seed_value(seed4), .pattern(pat4)
  );

  ca_pattern_gen #(
    .CELLS(7), .RULE_BITS(7), .RULES(7'b1101010), .RESET_SEED(7'd1)
  ) u_ca_pattern_gen_w7 (
    .clk(clk), .rst_n(rst_n), .step_en(en7), .seed_load(ld7),
    .seed_value(seed7), .pattern(pat7)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(input logic en, input logic ld, input logic [3:0] sd,
                       input logic [3:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    en4 = en; ld4 = ld; seed4 = sd;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(it.tag, pat4, it.exp);
      end
    end
  end

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int idx;
    logic [127:0] seen;
    int first_ret, bad;
    checks = 0; errors = 0;
    rst_n = 1'b0;
    en4 = 0; ld4 = 0; seed4 = '0;
    en7 = 0; ld7 = 0; seed7 = '0;
    repeat (3) @(negedge clk);
    chk("R1", pat4, 4'h1);
    rst_n = 1'b1;
    // R1 and R2: idle cycles across the synchronized release
    for (int k = 0; k < 4; k++) drive(0, 0, 4'h0, 4'h1, "R1");
    // R5: first step from 0x1 with zero boundaries
    drive(1, 0, 4'h0, 4'h3, "R5");
    idx = 7;
    // R4: continue stepping through the orbit
    for (int k = 0; k < 5; k++) begin
      idx = (idx + 1) % 15;
      drive(1, 0, 4'h0, orbit[idx], "R4");
    end
    // R2: hold
    for (int k = 0; k < 3; k++) drive(0, 0, 4'h9, orbit[idx], "R2");
    // R3: plain load of 0x8, then R6 full orbit and wrap
    drive(0, 1, 4'h8, 4'h8, "R3");
    for (int k = 1; k <= 15; k++) drive(1, 0, 4'h0, orbit[k % 15], "R6");
    // R3: load and step in the same cycle, load wins
    drive(1, 1, 4'h6, 4'h6, "R3");
    drive(1, 0, 4'h0, 4'hB, "R4");
    // R8: zero lock-up
    drive(0, 1, 4'h0, 4'h0, "R3");
    for (int k = 0; k < 3; k++) drive(1, 0, 4'h0, 4'h0, "R8");
    // R3 then R4 from 0x5
    drive(1, 1, 4'h5, 4'h5, "R3");
    drive(1, 0, 4'h0, 4'hD, "R4");
    drive(0, 0, 4'h0, 4'hD, "R2");
    @(negedge clk);
    @(negedge clk);
    // R1: asynchronous reset assertion mid-run
    rst_n = 1'b0;
    #1;
    chk("R1", pat4, 4'h1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) drive(0, 0, 4'h0, 4'h1, "R1");
    @(negedge clk);
    @(negedge clk);

    // R7: 7-cell maximal-length orbit
    ld7 = 1'b1; seed7 = 7'd1;
    @(posedge clk); #1;
    @(negedge clk);
    ld7 = 1'b0; en7 = 1'b1;
    seen = '0; seen[1] = 1'b1;
    first_ret = -1; bad = 0;
    for (int k = 1; k <= 127; k++) begin
      @(posedge clk); #1;
      if (pat7 == 7'd0) bad++;
      else if (pat7 == 7'd1) begin
        if (first_ret < 0) first_ret = k;
      end else if (seen[pat7]) bad++;
      seen[pat7] = 1'b1;
    end
    @(negedge clk);
    en7 = 1'b0;
    chk("R7", first_ret, 127);
    chk("R7", bad, 0);
    @(posedge clk); #1;
    chk("R2", pat7, 7'd1);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule